// File: doc/BRIEF.md
# Interval Path Update Engine

The engine keeps the most likely explanation of a stream of scene segments. Each segment is a run of frames that share one small state code. The code is formed from a few binary detection zones. A stretch of contiguous segments is called an interval, and each interval is labelled with one of three modes: nobody present, a crossing in one direction, or a crossing in the other direction. When a segment ends, the caller presents the segment's state code and its duration. The engine then updates a store of recent start nodes. For every node still inside the duration limit, it extends that node's cached per-mode likelihood products with transition probabilities taken from lookup tables. It then picks the best mode for that interval and keeps the highest-cost path that ends at the new node.

All probabilities are unsigned fractions. Table entries are 8 bits wide and every other value is 16 bits wide, so a code of all ones stands just below 1.0. The tables are written from outside through a simple write port and should be left unchanged while an update runs. The engine reports the winning path cost, the mode of the last interval on that path, and how many segments that interval spans. The next update uses the reported cost as the path cost into the node that comes after.

Top module: `ipath_update`

## Requirements
- R1: After reset, busy, seg_err, done, best_cost, best_mode and best_len are all 0. The node store is empty. The path cost carried into the next node is 16'hFFFF, and both remembered earlier states are 0.
- R2: When tbl_we is high at a clock edge, tbl_data is written into the table of mode tbl_mode. Mode codes are 0 for none, 1 for in and 2 for out. tbl_order picks the table and the index layout: 0 is the start table, indexed by tbl_idx[SW-1:0] = current state. 1 is the first-order table, indexed by tbl_idx[2SW-1:0] = {one back, current}. 2 is the second-order table, indexed by tbl_idx = {two back, one back, current}.
- R3: Every update evaluates the interval made of the new segment alone. Its per-mode likelihood is {start entry, 8'h00}, and its path cost is the carried cost multiplied by the best of those likelihoods. On the first update after reset it is the only candidate, so best_len is 1.
- R4: A stored node whose interval held one segment is extended with the first-order entry. A node whose interval held more is extended with the second-order entry. Both lookups are addressed by the remembered earlier states and the new state.
- R5: A product of a 16-bit value and an 8-bit entry keeps bits [23:8]. A product of two 16-bit values keeps bits [31:16]. All comparisons are unsigned.
- R6: The likelihood of an interval is the largest of its three mode values. On a tie the lower mode code wins.
- R7: A stored node whose accumulated duration plus the new duration exceeds TMAX is removed for good. A sum equal to TMAX keeps the node.
- R8: Candidates are compared oldest node first, then the single-segment interval. A later candidate replaces the running best only if it is strictly greater. best_len equals the number of segments in the winning interval.
- R9: Each kept node is written back with its updated duration, likelihoods and segment count. The new node is stored with the carried cost, the start likelihoods and the new duration. The winning cost then becomes the carried cost.
- R10: If DEPTH nodes remain after the scan, the oldest one is discarded before the new node is stored.
- R11: busy rises at the edge that accepts seg_valid. It stays high for one cycle per node held at acceptance, plus one more cycle.
- R12: A seg_valid seen while busy is high is ignored and raises seg_err for exactly the next cycle.
- R13: done is a one-cycle pulse at the edge where busy falls. best_cost, best_mode and best_len are updated at that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| seg_valid | input | 1 | A segment has ended |
| seg_state | input | SW | State code of the ended segment |
| seg_dur | input | TW | Duration of the ended segment in frames |
| tbl_we | input | 1 | Table write strobe |
| tbl_mode | input | 2 | Mode whose table is written |
| tbl_order | input | 2 | Table selector (start, first, second order) |
| tbl_idx | input | 3*SW | Table entry index |
| tbl_data | input | 8 | Probability to write |
| busy | output | 1 | Update in progress |
| seg_err | output | 1 | Segment rejected while busy |
| done | output | 1 | Result valid pulse |
| best_cost | output | 16 | Cost of the best path to the new node |
| best_mode | output | 2 | Mode of the last interval on that path |
| best_len | output | clog2(DEPTH+2) | Segments in that interval |

## Verification
The hardest situations to reach from the ports are a full node store and exact ties between candidates. With ordinary likelihoods, the winning length hides which nodes are still stored. So the bench loads all-zero tables, which makes every candidate tie at zero. The oldest surviving node then always wins, and best_len shows directly how many nodes remain. A run of short segments reveals the capacity limit, and durations summing exactly to the limit, or one frame past it, reveal the drop rule. A patterned table walk checked against a bench model covers the arithmetic, and one segment pushed in mid-update covers rejection.

// File: rtl/ipath_pkg.sv
package ipath_pkg;
   localparam int NMODE = 3;
   localparam int PW    = 8;
   localparam int CW    = 16;

   typedef logic [CW-1:0] prob16_t;

   typedef enum logic [1:0] {
      TBL_START  = 2'd0,
      TBL_FIRST  = 2'd1,
      TBL_SECOND = 2'd2
   } tbl_order_e;

   // fraction x 8-bit entry, upper 16 bits kept
   function automatic prob16_t scale8(prob16_t a, logic [PW-1:0] b);
      logic [CW+PW-1:0] p;
      p = a * b;
      return p[CW+PW-1:PW];
   endfunction

   // fraction x fraction, upper 16 bits kept
   function automatic prob16_t scale16(prob16_t a, prob16_t b);
      logic [2*CW-1:0] p;
      p = a * b;
      return p[2*CW-1:CW];
   endfunction
endpackage

// File: rtl/ipath_prob_tables.sv
module ipath_prob_tables
   import ipath_pkg::*;
#(
   parameter int SW = 2
)(
   input  logic                        clk,
   input  logic                        we,
   input  logic [1:0]                  wr_mode,
   input  logic [1:0]                  wr_order,
   input  logic [3*SW-1:0]             wr_idx,
   input  logic [PW-1:0]               wr_data,
   input  logic [SW-1:0]               st_cur,
   input  logic [SW-1:0]               st_m1,
   input  logic [SW-1:0]               st_m2,
   output logic [NMODE-1:0][PW-1:0]    p_start,
   output logic [NMODE-1:0][PW-1:0]    p_first,
   output logic [NMODE-1:0][PW-1:0]    p_second
);
   localparam int N0 = 2**SW;
   localparam int N1 = 2**(2*SW);
   localparam int N2 = 2**(3*SW);

   if (SW < 1 || SW > 3) begin : g_bad_sw
      $error("ipath_prob_tables: SW out of range");
   end

   for (genvar k = 0; k < NMODE; k++) begin : g_mode
      logic [PW-1:0] t0 [N0];
      logic [PW-1:0] t1 [N1];
      logic [PW-1:0] t2 [N2];

      always_ff @(posedge clk) begin
         if (we && wr_mode == 2'(k)) begin
            case (tbl_order_e'(wr_order))
               TBL_START:  t0[wr_idx[SW-1:0]]   <= wr_data;
               TBL_FIRST:  t1[wr_idx[2*SW-1:0]] <= wr_data;
               TBL_SECOND: t2[wr_idx]           <= wr_data;
               default: ;
            endcase
         end
      end

      assign p_start[k]  = t0[st_cur];
      assign p_first[k]  = t1[{st_m1, st_cur}];
      assign p_second[k] = t2[{st_m2, st_m1, st_cur}];
   end
endmodule

// File: rtl/ipath_mode_max.sv
module ipath_mode_max
   import ipath_pkg::*;
(
   input  logic [NMODE-1:0][CW-1:0] lik,
   output prob16_t                  best,
   output logic [1:0]               idx
);
   // R6: strict greater-than keeps the lower mode code on a tie
   always_comb begin
      best = lik[0];
      idx  = 2'd0;
      for (int k = 1; k < NMODE; k++) begin
         if (lik[k] > best) begin
            best = lik[k];
            idx  = 2'(k);
         end
      end
   end
endmodule

// File: rtl/ipath_node_store.sv
module ipath_node_store #(
   parameter int W     = 8,
   parameter int DEPTH = 8
)(
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           push,
   input  logic                           pop,
   input  logic [W-1:0]                   wdata,
   output logic [W-1:0]                   rdata,
   output logic [$clog2(DEPTH+1)-1:0]     count
);
   localparam int AW   = $clog2(DEPTH);
   localparam int CNTW = $clog2(DEPTH+1);
   localparam logic [AW-1:0]   LAST  = AW'(DEPTH-1);
   localparam logic [CNTW-1:0] FULLC = CNTW'(DEPTH);

   if (DEPTH < 2) begin : g_bad_depth
      $error("ipath_node_store: DEPTH must be at least 2");
   end

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] rd_ptr, wr_ptr;

   assign rdata = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_ptr <= '0;
         wr_ptr <= '0;
         count  <= '0;
      end else begin
         if (push) begin
            mem[wr_ptr] <= wdata;
            wr_ptr      <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
         end
         if (pop) rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
         count <= count + CNTW'(push) - CNTW'(pop);
      end
   end

   a_r10_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      push && !pop |-> count < FULLC);
   a_r10_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> count != '0);
endmodule

// File: rtl/ipath_update.sv
module ipath_update
   import ipath_pkg::*;
#(
   parameter int SW    = 2,
   parameter int TW    = 8,
   parameter int DEPTH = 8,
   parameter int TMAX  = 60
)(
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          seg_valid,
   input  logic [SW-1:0]                 seg_state,
   input  logic [TW-1:0]                 seg_dur,
   input  logic                          tbl_we,
   input  logic [1:0]                    tbl_mode,
   input  logic [1:0]                    tbl_order,
   input  logic [3*SW-1:0]               tbl_idx,
   input  logic [PW-1:0]                 tbl_data,
   output logic                          busy,
   output logic                          seg_err,
   output logic                          done,
   output logic [CW-1:0]                 best_cost,
   output logic [1:0]                    best_mode,
   output logic [$clog2(DEPTH+2)-1:0]    best_len
);
   localparam int LW   = $clog2(DEPTH+2);
   localparam int CNTW = $clog2(DEPTH+1);
   localparam logic [TW:0]     TMAX_V = (TW+1)'(TMAX);
   localparam logic [CNTW-1:0] FULL_V = CNTW'(DEPTH);
   localparam logic [LW-1:0]   ONE_L  = LW'(1);

   if (TMAX < 1 || TMAX >= 2**TW) begin : g_bad_tmax
      $error("ipath_update: TMAX must fit in TW bits");
   end

   typedef struct packed {
      logic [LW-1:0]               nseg;
      prob16_t                     cost;
      logic [NMODE-1:0][CW-1:0]    part;
      logic [TW-1:0]               acc;
   } node_t;
   localparam int EW = $bits(node_t);

   typedef enum logic [1:0] {ST_IDLE, ST_SCAN, ST_FIN} ctl_e;

   ctl_e                       st;
   logic [SW-1:0]              ev_state, hist1, hist2;
   logic [TW-1:0]              ev_dur;
   prob16_t                    pend_cost, run_cost;
   logic                       run_v;
   logic [1:0]                 run_mode;
   logic [LW-1:0]              run_len;
   logic [CNTW-1:0]            left, fill;
   logic [EW-1:0]              rd_flat, wr_flat;
   node_t                      head, upd_node, new_node;
   logic                       st_push, st_pop;
   logic [NMODE-1:0][PW-1:0]   p_start, p_first, p_second;
   logic [NMODE-1:0][CW-1:0]   ext_part, init_part;
   prob16_t                    scan_lik, fin_lik, scan_cand, fin_cand;
   logic [1:0]                 scan_mode, fin_mode;
   logic [TW:0]                acc_sum;
   logic                       keep, scan_take, fin_take;

   ipath_prob_tables #(.SW(SW)) u_tables (
      .clk(clk), .we(tbl_we), .wr_mode(tbl_mode), .wr_order(tbl_order),
      .wr_idx(tbl_idx), .wr_data(tbl_data),
      .st_cur(ev_state), .st_m1(hist1), .st_m2(hist2),
      .p_start(p_start), .p_first(p_first), .p_second(p_second));

   ipath_node_store #(.W(EW), .DEPTH(DEPTH)) u_store (
      .clk(clk), .rst_n(rst_n), .push(st_push), .pop(st_pop),
      .wdata(wr_flat), .rdata(rd_flat), .count(fill));

   assign head = node_t'(rd_flat);

   // R4: first-order entry for one-segment intervals, second-order beyond
   for (genvar k = 0; k < NMODE; k++) begin : g_lik
      assign ext_part[k]  = scale8(head.part[k],
                                   (head.nseg == ONE_L) ? p_first[k] : p_second[k]);
      assign init_part[k] = {p_start[k], {(CW-PW){1'b0}}};
   end

   ipath_mode_max u_scan_max (.lik(ext_part),  .best(scan_lik), .idx(scan_mode));
   ipath_mode_max u_fin_max  (.lik(init_part), .best(fin_lik),  .idx(fin_mode));

   always_comb begin
      acc_sum   = {1'b0, head.acc} + {1'b0, ev_dur};
      keep      = acc_sum <= TMAX_V;
      scan_cand = scale16(head.cost, scan_lik);
      fin_cand  = scale16(pend_cost, fin_lik);
      scan_take = keep && (!run_v || scan_cand > run_cost);
      fin_take  = !run_v || fin_cand > run_cost;
      upd_node  = '{nseg: head.nseg + ONE_L, cost: head.cost, part: ext_part,
                    acc: acc_sum[TW-1:0]};
      new_node  = '{nseg: ONE_L, cost: pend_cost, part: init_part, acc: ev_dur};
      st_pop    = (st == ST_SCAN) || (st == ST_FIN && fill == FULL_V);
      st_push   = (st == ST_SCAN && keep) || (st == ST_FIN);
      wr_flat   = (st == ST_FIN) ? new_node : upd_node;
      busy      = (st != ST_IDLE);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st        <= ST_IDLE;
         ev_state  <= '0;
         ev_dur    <= '0;
         hist1     <= '0;
         hist2     <= '0;
         pend_cost <= '1;
         run_v     <= 1'b0;
         run_cost  <= '0;
         run_mode  <= '0;
         run_len   <= '0;
         left      <= '0;
         seg_err   <= 1'b0;
         done      <= 1'b0;
         best_cost <= '0;
         best_mode <= '0;
         best_len  <= '0;
      end else begin
         done    <= 1'b0;
         seg_err <= seg_valid && (st != ST_IDLE);
         case (st)
            ST_IDLE: if (seg_valid) begin
               ev_state <= seg_state;
               ev_dur   <= seg_dur;
               run_v    <= 1'b0;
               left     <= fill;
               st       <= (fill == '0) ? ST_FIN : ST_SCAN;
            end
            ST_SCAN: begin
               if (scan_take) begin
                  run_v    <= 1'b1;
                  run_cost <= scan_cand;
                  run_mode <= scan_mode;
                  run_len  <= head.nseg + ONE_L;
               end
               left <= left - 1'b1;
               if (left == CNTW'(1)) st <= ST_FIN;
            end
            ST_FIN: begin
               best_cost <= fin_take ? fin_cand : run_cost;
               best_mode <= fin_take ? fin_mode : run_mode;
               best_len  <= fin_take ? ONE_L    : run_len;
               pend_cost <= fin_take ? fin_cand : run_cost;
               hist2     <= hist1;
               hist1     <= ev_state;
               done      <= 1'b1;
               st        <= ST_IDLE;
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   a_r12_reject_flag: assert property (@(posedge clk) disable iff (!rst_n)
      seg_valid && busy |=> seg_err);
   a_r12_no_flag_idle: assert property (@(posedge clk) disable iff (!rst_n)
      seg_valid && !busy |=> !seg_err);
   a_r11_busy_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(seg_valid));
   a_r13_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   a_r13_done_at_end: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy && $past(busy));
   a_r8_len_range: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> best_len != '0 && best_len <= LW'(DEPTH+1));
   a_r6_mode_legal: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> best_mode != 2'd3);
endmodule

// File: tb/tb_ipath_update.sv
module tb_ipath_update;
   localparam int SW = 2, TW = 8, DEPTH = 8, TMAX = 60;
   localparam int LW = $clog2(DEPTH+2);
   localparam int NV = 24;
   // {state[9:8], duration[7:0]}
   localparam logic [9:0] VEC [NV] = '{
      {2'd1,8'd4},  {2'd3,8'd5},  {2'd2,8'd3},  {2'd0,8'd4},  {2'd1,8'd5},  {2'd3,8'd3},
      {2'd2,8'd4},  {2'd1,8'd3},  {2'd0,8'd5},  {2'd2,8'd4},  {2'd3,8'd3},  {2'd1,8'd4},
      {2'd2,8'd20}, {2'd0,8'd25}, {2'd3,8'd3},  {2'd1,8'd40}, {2'd2,8'd8},  {2'd0,8'd61},
      {2'd1,8'd2},  {2'd3,8'd9},  {2'd2,8'd30}, {2'd0,8'd0},  {2'd1,8'd6},  {2'd3,8'd12}};

   logic clk, rst_n, seg_valid, tbl_we, busy, seg_err, done;
   logic [SW-1:0] seg_state;
   logic [TW-1:0] seg_dur;
   logic [1:0] tbl_mode, tbl_order, best_mode;
   logic [3*SW-1:0] tbl_idx;
   logic [7:0] tbl_data;
   logic [15:0] best_cost;
   logic [LW-1:0] best_len;

   ipath_update #(.SW(SW), .TW(TW), .DEPTH(DEPTH), .TMAX(TMAX)) dut (
      .clk(clk), .rst_n(rst_n), .seg_valid(seg_valid), .seg_state(seg_state),
      .seg_dur(seg_dur), .tbl_we(tbl_we), .tbl_mode(tbl_mode), .tbl_order(tbl_order),
      .tbl_idx(tbl_idx), .tbl_data(tbl_data), .busy(busy), .seg_err(seg_err),
      .done(done), .best_cost(best_cost), .best_mode(best_mode), .best_len(best_len));

   initial clk = 1'b0;
   always #10 clk = ~clk;

   int n_checks = 0, n_fail = 0;

   // bench model state
   logic [7:0] bt0 [3][4];
   logic [7:0] bt1 [3][16];
   logic [7:0] bt2 [3][64];
   longint m_acc [DEPTH];
   longint m_cost [DEPTH];
   longint m_part [DEPTH][3];
   int     m_n [DEPTH];
   int     m_cnt, m_h1, m_h2;
   longint m_pend;
   longint e_cost;
   int     e_mode, e_len, e_scan, last_busy;

   task automatic chk(input string req, input string what, input longint act, input longint exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic logic [7:0] tbl_val(int kind, int m, int o, int idx);
      if (kind == 1) return 8'd0;
      if (kind == 2) return 8'hFF;
      return 8'(((m*37 + o*59 + idx*11 + 17) % 200) + 40);
   endfunction

   // R2: table write encoding
   task automatic load_tables(int kind);
      for (int m = 0; m < 3; m++) begin
         for (int o = 0; o < 3; o++) begin
            for (int i = 0; i < (o == 0 ? 4 : (o == 1 ? 16 : 64)); i++) begin
               @(negedge clk);
               tbl_we = 1'b1; tbl_mode = 2'(m); tbl_order = 2'(o);
               tbl_idx = 6'(i); tbl_data = tbl_val(kind, m, o, i);
               if (o == 0) bt0[m][i] = tbl_data;
               else if (o == 1) bt1[m][i] = tbl_data;
               else bt2[m][i] = tbl_data;
            end
         end
      end
      @(negedge clk);
      tbl_we = 1'b0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; seg_valid = 1'b0; tbl_we = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      m_cnt = 0; m_pend = 65535; m_h1 = 0; m_h2 = 0;
      @(negedge clk);
   endtask

   task automatic model_event(int s, int d);
      longint tacc [DEPTH+1];
      longint tcost [DEPTH+1];
      longint tpart [DEPTH+1][3];
      int     tn [DEPTH+1];
      longint np [3];
      longint lik, c, bc, a;
      int tc, bm, bl, lm;
      bit bv;
      tc = 0; bv = 0; bc = 0; bm = 0; bl = 0;
      e_scan = m_cnt;
      for (int i = 0; i < m_cnt; i++) begin
         a = m_acc[i] + d;
         if (a <= TMAX) begin
            for (int k = 0; k < 3; k++) begin
               longint p;
               p = (m_n[i] == 1) ? longint'(bt1[k][m_h1*4 + s])
                                 : longint'(bt2[k][m_h2*16 + m_h1*4 + s]);
               np[k] = (m_part[i][k] * p) >> 8;
            end
            lik = np[0]; lm = 0;
            for (int k = 1; k < 3; k++) if (np[k] > lik) begin lik = np[k]; lm = k; end
            c = (m_cost[i] * lik) >> 16;
            if (!bv || c > bc) begin bv = 1; bc = c; bm = lm; bl = m_n[i] + 1; end
            tacc[tc] = a; tcost[tc] = m_cost[i]; tn[tc] = m_n[i] + 1;
            for (int k = 0; k < 3; k++) tpart[tc][k] = np[k];
            tc++;
         end
      end
      for (int k = 0; k < 3; k++) np[k] = longint'(bt0[k][s]) << 8;
      lik = np[0]; lm = 0;
      for (int k = 1; k < 3; k++) if (np[k] > lik) begin lik = np[k]; lm = k; end
      c = (m_pend * lik) >> 16;
      if (!bv || c > bc) begin bv = 1; bc = c; bm = lm; bl = 1; end
      if (tc == DEPTH) begin
         for (int i = 0; i < DEPTH-1; i++) begin
            tacc[i] = tacc[i+1]; tcost[i] = tcost[i+1]; tn[i] = tn[i+1];
            for (int k = 0; k < 3; k++) tpart[i][k] = tpart[i+1][k];
         end
         tc--;
      end
      tacc[tc] = d; tcost[tc] = m_pend; tn[tc] = 1;
      for (int k = 0; k < 3; k++) tpart[tc][k] = np[k];
      tc++;
      for (int i = 0; i < tc; i++) begin
         m_acc[i] = tacc[i]; m_cost[i] = tcost[i]; m_n[i] = tn[i];
         for (int k = 0; k < 3; k++) m_part[i][k] = tpart[i][k];
      end
      m_cnt = tc; m_pend = bc; m_h2 = m_h1; m_h1 = s;
      e_cost = bc; e_mode = bm; e_len = bl;
   endtask

   task automatic run_event(int s, int d, bit intrude);
      int g, bcnt;
      model_event(s, d);
      @(negedge clk);
      seg_valid = 1'b1; seg_state = 2'(s); seg_dur = 8'(d);
      @(negedge clk);
      seg_valid = 1'b0;
      bcnt = 0; g = 0;
      if (intrude) begin
         if (busy) bcnt++;
         seg_valid = 1'b1; seg_state = 2'(s ^ 3); seg_dur = 8'd1;
         @(negedge clk);
         seg_valid = 1'b0;
         chk("R12", "seg_err after event while busy", seg_err, 1);
      end
      while (!done && g < 500) begin
         if (busy) bcnt++;
         @(negedge clk);
         g++;
      end
      chk("R13", "done seen", done, 1);
      chk("R4/R5/R9", "best_cost", best_cost, e_cost);
      chk("R6", "best_mode", best_mode, e_mode);
      chk("R8", "best_len", best_len, e_len);
      chk("R11", "busy cycles", bcnt, e_scan + 1);
      last_busy = bcnt;
      @(negedge clk);
      chk("R13", "done is one cycle", done, 0);
   endtask

   initial begin
      #(20 * 150000);
      n_checks++; n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
   end

   initial begin
      longint fexp;
      int mx;
      rst_n = 1'b0; seg_valid = 1'b0; seg_state = '0; seg_dur = '0;
      tbl_we = 1'b0; tbl_mode = '0; tbl_order = '0; tbl_idx = '0; tbl_data = '0;
      do_reset();
      chk("R1", "busy", busy, 0);
      chk("R1", "done", done, 0);
      chk("R1", "seg_err", seg_err, 0);
      chk("R1", "best_cost", best_cost, 0);
      chk("R1", "best_mode", best_mode, 0);
      chk("R1", "best_len", best_len, 0);

      // patterned tables, vector walk against the model
      load_tables(0);
      mx = 0;
      for (int k = 0; k < 3; k++) if (int'(bt0[k][VEC[0][9:8]]) > mx) mx = int'(bt0[k][VEC[0][9:8]]);
      fexp = (longint'(65535) * (longint'(mx) << 8)) >> 16;
      for (int v = 0; v < NV; v++) begin
         run_event(int'(VEC[v][9:8]), int'(VEC[v][7:0]), v == 14);
         if (v == 0) begin
            chk("R2 R3", "first event cost", best_cost, fexp);
            chk("R3", "first event length", best_len, 1);
         end
      end
      chk("R12", "seg_err cleared", seg_err, 0);

      // R7 boundary: sum equal to TMAX keeps the node (zero tables force ties)
      load_tables(1);
      do_reset();
      run_event(0, 60, 0);
      run_event(1, 0, 0);
      chk("R7", "equal sum kept", best_len, 2);
      do_reset();
      run_event(0, 60, 0);
      run_event(1, 1, 0);
      chk("R7", "over limit dropped", best_len, 1);
      run_event(2, 1, 0);
      chk("R7", "dropped node stays gone", best_len, 2);
      chk("R8", "tie keeps oldest, cost zero", best_cost, 0);

      // R10 capacity: oldest discarded once DEPTH nodes remain
      do_reset();
      for (int i = 0; i < DEPTH + 3; i++) run_event(i % 4, 1, 0);
      chk("R10", "length capped", best_len, DEPTH + 1);
      chk("R10", "busy with full store", last_busy, DEPTH + 1);

      // R6 tie across modes
      load_tables(2);
      do_reset();
      run_event(3, 2, 0);
      run_event(1, 2, 0);
      chk("R6", "equal modes pick code 0", best_mode, 0);

      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
   end
endmodule